// File: doc/BRIEF.md
# Single-Channel TDC Hit Timestamping Front End

This block serves one channel of a multi-channel time-to-digital converter. On every rising edge of the conversion clock it receives a snapshot of a tapped delay line. The snapshot is a thermometer-coded vector: the number of set taps measures the time from the rising edge of the hit to the next rising edge of the clock. It also receives the value of a free-running coarse counter that all channels share.

A hit is a rising edge on tap 0 between two consecutive snapshots. For each accepted hit the block counts the set taps in a three-stage pipelined encoder. It delays the coarse stamp by the same three stages, so that both parts leave the pipeline in the same cycle. It then packs the channel number, the coarse stamp and the fine count into one word. The word goes into a small dual-clock FIFO whose read side runs on a slower readout clock.

After each accepted hit the channel is dead for a fixed number of cycles. A word that reaches a full FIFO is dropped, and a saturating counter records the drop.

Top module: `tdc_channel_front`

## Requirements
- R1: After reset `rd_empty` is 1 and `ovf_count` is 0.
- R2: A hit is seen only when tap 0 is 0 in one snapshot and 1 in the next. Tap 0 staying high produces no further hits. The snapshot taken in the first cycle after reset never counts as a hit.
- R3: If a hit is accepted in snapshot k, tap-0 rising edges in snapshots k+1 to k+DEAD_CYC-1 (default 6) are ignored, and an edge in snapshot k+DEAD_CYC is accepted.
- R4: The fine field equals the number of set taps in the snapshot of the hit. A pure thermometer code gives its length, and a zero bubble inside the run lowers the count by one.
- R5: The coarse field equals `coarse_cnt` as sampled on the same clock edge as the hit snapshot, including after the counter wraps.
- R6: Word layout: bits [WORD_W-1 -: 5] hold CHAN_ID, the next COARSE_W bits hold the coarse stamp, and the low FINE_W bits (9 for 288 taps) hold the fine count.
- R7: The word for a hit is presented to the FIFO exactly 3 conversion cycles after the hit snapshot edge. This is within the 9-cycle bound.
- R8: The read side is show-ahead. While `rd_empty` is 0, `rd_data` holds the oldest word and stays stable until `rd_en` pops it. `rd_en` has no effect while `rd_empty` is 1. Words leave in the order the hits were accepted.
- R9: A word that reaches a full FIFO is dropped, and `ovf_count` increments by one. `ovf_count` saturates at all-ones.
- R10: The FIFO holds 2^FIFO_AW (default 16) words before it reports full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| conv_clk | input | 1 | Conversion clock (delay-line sample clock) |
| conv_rst_n | input | 1 | Active-low asynchronous reset, conversion domain |
| tap_vec | input | TAPS | Delay-line snapshot, thermometer coded from tap 0 |
| coarse_cnt | input | COARSE_W | Shared free-running coarse counter |
| ovf_count | output | OVF_W | Saturating count of words dropped on a full FIFO |
| rd_clk | input | 1 | Readout clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, readout domain |
| rd_en | input | 1 | Pop the current word |
| rd_empty | output | 1 | No word available |
| rd_data | output | WORD_W | Oldest stored word (show-ahead) |

## Verification
The bench sends runs of snapshots in which tap 0 rises again inside the dead window, stays high across many samples, or carries a bubble, and it also sends all-taps and single-tap codes. A gate that counted the level instead of the edge, or that was off by one in the dead counter, would change the number of words read. A coarse pipeline that was one stage short or long would shift every coarse field by one count, and a long random run that wraps the counter exposes this. With the reader paused, more hits than the FIFO depth are sent: a wrong full flag would either lose one of the first 16 words or accept a 17th, and a counter that wraps would report a small value instead of all-ones. While the FIFO is empty, `rd_en` is toggled to catch a pointer that moves on a read from an empty FIFO.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  // channel tag width (32 channels)
  localparam int CHAN_W   = 5;
  // pipeline depth of the fine encoder; coarse stamp is delayed to match
  localparam int ENC_LAT  = 3;
  // taps summed per group in the first counting stage
  localparam int GRP_TAPS = 32;

  function automatic int div_ceil(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/tdc_hit_gate.sv
module tdc_hit_gate #(
  parameter int DEAD_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tap0,
  output logic hit_accept
);
  localparam int DCW = $clog2(DEAD_CYC + 1);

  logic           prev_tap0;
  logic [DCW-1:0] dead_left;
  logic           rise_seen;

  // prev resets high so a line already high after reset is not a hit
  assign rise_seen  = tap0 & ~prev_tap0;
  assign hit_accept = rise_seen & (dead_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_tap0 <= 1'b1;
      dead_left <= '0;
    end else begin
      prev_tap0 <= tap0;
      if (hit_accept)
        dead_left <= DCW'(DEAD_CYC - 1);
      else if (dead_left != '0)
        dead_left <= dead_left - 1'b1;
    end
  end
endmodule

// File: rtl/tdc_therm_encoder.sv
module tdc_therm_encoder
  import tdc_pkg::*;
#(
  parameter int TAPS   = 288,
  parameter int FINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [TAPS-1:0]   in_taps,
  output logic              out_valid,
  output logic [FINE_W-1:0] out_fine
);
  localparam int NGRP = div_ceil(TAPS, GRP_TAPS);
  localparam int PADW = NGRP * GRP_TAPS;
  localparam int GCW  = $clog2(GRP_TAPS + 1);

  function automatic logic [GCW-1:0] grp_ones(input logic [GRP_TAPS-1:0] s);
    logic [GCW-1:0] c;
    c = '0;
    for (int i = 0; i < GRP_TAPS; i++) c = c + GCW'(s[i]);
    return c;
  endfunction

  logic [PADW-1:0]   padded;
  logic [PADW-1:0]   cap_taps;
  logic              v1, v2;
  logic [GCW-1:0]    grp_cnt [NGRP];
  logic [FINE_W-1:0] fsum;

  assign padded = PADW'(in_taps);

  // stage 1: capture snapshot of accepted hit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_taps <= '0;
      v1       <= 1'b0;
    end else begin
      v1 <= in_valid;
      if (in_valid) cap_taps <= padded;
    end
  end

  // stage 2: per-group ones count
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grp_cnt[g] <= '0;
      else        grp_cnt[g] <= grp_ones(cap_taps[g*GRP_TAPS +: GRP_TAPS]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v2 <= 1'b0;
    else        v2 <= v1;
  end

  // stage 3: total
  always_comb begin
    fsum = '0;
    for (int g = 0; g < NGRP; g++) fsum = fsum + FINE_W'(grp_cnt[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fine  <= '0;
    end else begin
      out_valid <= v2;
      out_fine  <= fsum;
    end
  end
endmodule

// File: rtl/tdc_stage_delay.sv
module tdc_stage_delay #(
  parameter int W     = 11,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/tdc_xclk_fifo.sv
module tdc_xclk_fifo #(
  parameter int DW = 25,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_pop,
  output logic          rd_empty,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wbin, wgray, rgray_w1, rgray_w2;
  logic [AW:0]   rbin, rgray, wgray_r1, wgray_r2;
  logic          do_wr, do_rd;

  // write domain
  assign wr_full = (wgray == {~rgray_w2[AW:AW-1], rgray_w2[AW-2:0]});
  assign do_wr   = wr_req & ~wr_full;

  always_ff @(posedge wr_clk) begin
    if (do_wr) mem[wbin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rgray_w1 <= '0;
      rgray_w2 <= '0;
    end else begin
      rgray_w1 <= rgray;
      rgray_w2 <= rgray_w1;
      if (do_wr) begin
        wbin  <= wbin + 1'b1;
        wgray <= to_gray(wbin + 1'b1);
      end
    end
  end

  // read domain
  assign rd_empty = (rgray == wgray_r2);
  assign do_rd    = rd_pop & ~rd_empty;
  assign rd_data  = mem[rbin[AW-1:0]];

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wgray_r1 <= '0;
      wgray_r2 <= '0;
    end else begin
      wgray_r1 <= wgray;
      wgray_r2 <= wgray_r1;
      if (do_rd) begin
        rbin  <= rbin + 1'b1;
        rgray <= to_gray(rbin + 1'b1);
      end
    end
  end
endmodule

// File: rtl/tdc_channel_front.sv
module tdc_channel_front
  import tdc_pkg::*;
#(
  parameter int TAPS     = 288,
  parameter int COARSE_W = 11,
  parameter int CHAN_ID  = 0,
  parameter int DEAD_CYC = 6,
  parameter int FIFO_AW  = 4,
  parameter int OVF_W    = 8,
  localparam int FINE_W  = $clog2(TAPS + 1),
  localparam int WORD_W  = CHAN_W + COARSE_W + FINE_W
) (
  input  logic                conv_clk,
  input  logic                conv_rst_n,
  input  logic [TAPS-1:0]     tap_vec,
  input  logic [COARSE_W-1:0] coarse_cnt,
  output logic [OVF_W-1:0]    ovf_count,
  input  logic                rd_clk,
  input  logic                rd_rst_n,
  input  logic                rd_en,
  output logic                rd_empty,
  output logic [WORD_W-1:0]   rd_data
);
  // named internal events (observed by the bound checker)
  logic                hit_accept;
  logic                enc_valid;
  logic [FINE_W-1:0]   enc_fine;
  logic [COARSE_W-1:0] stamp_aligned;
  logic [COARSE_W-1:0] stamp_held;
  logic [WORD_W-1:0]   word;
  logic                wr_full;
  logic                wr_fire;
  logic                drop_pulse;
  logic                rd_pop;

  tdc_hit_gate #(.DEAD_CYC(DEAD_CYC)) u_gate (
    .clk        (conv_clk),
    .rst_n      (conv_rst_n),
    .tap0       (tap_vec[0]),
    .hit_accept (hit_accept)
  );

  tdc_therm_encoder #(.TAPS(TAPS), .FINE_W(FINE_W)) u_enc (
    .clk       (conv_clk),
    .rst_n     (conv_rst_n),
    .in_valid  (hit_accept),
    .in_taps   (tap_vec),
    .out_valid (enc_valid),
    .out_fine  (enc_fine)
  );

  // coarse stamp: take it in the hit cycle, then delay to match the encoder
  assign stamp_held = coarse_cnt;

  tdc_stage_delay #(.W(COARSE_W), .DEPTH(ENC_LAT)) u_dly (
    .clk   (conv_clk),
    .rst_n (conv_rst_n),
    .din   (stamp_held),
    .dout  (stamp_aligned)
  );

  assign word       = {CHAN_W'(CHAN_ID), stamp_aligned, enc_fine};
  assign wr_fire    = enc_valid & ~wr_full;
  assign drop_pulse = enc_valid & wr_full;

  always_ff @(posedge conv_clk or negedge conv_rst_n) begin
    if (!conv_rst_n)                          ovf_count <= '0;
    else if (drop_pulse && ovf_count != '1)   ovf_count <= ovf_count + 1'b1;
  end

  assign rd_pop = rd_en & ~rd_empty;

  tdc_xclk_fifo #(.DW(WORD_W), .AW(FIFO_AW)) u_fifo (
    .wr_clk   (conv_clk),
    .wr_rst_n (conv_rst_n),
    .wr_req   (enc_valid),
    .wr_data  (word),
    .wr_full  (wr_full),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_pop   (rd_pop),
    .rd_empty (rd_empty),
    .rd_data  (rd_data)
  );
endmodule

module tdc_channel_front_chk #(
  parameter int DEAD_CYC = 6,
  parameter int OVF_W    = 8,
  parameter int WORD_W   = 25
) (
  input logic              conv_clk,
  input logic              conv_rst_n,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              hit_accept,
  input logic              wr_fire,
  input logic              drop_pulse,
  input logic              wr_full,
  input logic [OVF_W-1:0]  ovf_count,
  input logic              rd_empty,
  input logic              rd_pop,
  input logic [WORD_W-1:0] rd_data
);
  localparam int GW = $clog2(DEAD_CYC + 1);
  logic [GW-1:0] since_hit;

  always_ff @(posedge conv_clk or negedge conv_rst_n) begin
    if (!conv_rst_n)                 since_hit <= GW'(DEAD_CYC);
    else if (hit_accept)             since_hit <= GW'(1);
    else if (since_hit < GW'(DEAD_CYC)) since_hit <= since_hit + 1'b1;
  end

  // R3
  dead_window_chk: assert property (@(posedge conv_clk) disable iff (!conv_rst_n)
    hit_accept |-> since_hit >= GW'(DEAD_CYC));

  // R7
  enc_latency_chk: assert property (@(posedge conv_clk) disable iff (!conv_rst_n)
    hit_accept |-> ##3 (wr_fire || drop_pulse));

  // R7
  no_spurious_wr_chk: assert property (@(posedge conv_clk) disable iff (!conv_rst_n)
    (wr_fire || drop_pulse) |-> $past(hit_accept, 3));

  // R9
  full_block_chk: assert property (@(posedge conv_clk) disable iff (!conv_rst_n)
    wr_fire |-> !wr_full);

  // R9
  ovf_step_chk: assert property (@(posedge conv_clk) disable iff (!conv_rst_n)
    drop_pulse |=> (ovf_count == OVF_W'($past(ovf_count) + 1'b1)) || ($past(ovf_count) == '1));

  // R8
  head_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!rd_empty && !rd_pop) |=> $stable(rd_data));
endmodule

bind tdc_channel_front tdc_channel_front_chk #(
  .DEAD_CYC(DEAD_CYC), .OVF_W(OVF_W), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/tdc_channel_front_test.sv
module tdc_channel_front_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TAPS = 288, COARSE_W = 11, FINE_W = 9, CHW = 5;
  localparam int AW = 4, DEPTH = 16, OVF_W = 8, DEAD = 6, CHAN = 19;
  localparam int WORD_W = CHW + COARSE_W + FINE_W;

  logic                conv_clk = 0, rd_clk = 0;
  logic                conv_rst_n = 0, rd_rst_n = 0;
  logic [TAPS-1:0]     tap_vec = '0;
  logic [COARSE_W-1:0] coarse_cnt = '0;
  logic [OVF_W-1:0]    ovf_count;
  logic                rd_en = 0;
  logic                rd_empty;
  logic [WORD_W-1:0]   rd_data;

  tdc_channel_front #(.TAPS(TAPS), .COARSE_W(COARSE_W), .CHAN_ID(CHAN),
    .DEAD_CYC(DEAD), .FIFO_AW(AW), .OVF_W(OVF_W)) uut (
    .conv_clk(conv_clk), .conv_rst_n(conv_rst_n), .tap_vec(tap_vec),
    .coarse_cnt(coarse_cnt), .ovf_count(ovf_count), .rd_clk(rd_clk),
    .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_empty(rd_empty), .rd_data(rd_data));

  always #2   conv_clk = ~conv_clk;   // 250 MHz
  always #4.5 rd_clk   = ~rd_clk;

  int checks = 0, fails = 0, words_read = 0;
  bit rd_go = 0, done = 0;
  logic [WORD_W-1:0] exp_q [$];
  bit m_prev0 = 1;
  int m_dead = 0, m_ovf = 0;
  logic [COARSE_W-1:0] cval = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [TAPS-1:0] therm(input int n);
    logic [TAPS-1:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  // expected word from requirement fields (R6 layout)
  function automatic logic [WORD_W-1:0] mk_word(input logic [COARSE_W-1:0] c, input int f);
    return {CHW'(CHAN), c, FINE_W'(f)};
  endfunction

  // one conversion cycle: drive snapshot + coarse, update the reference model
  task automatic step(input logic [TAPS-1:0] v);
    bit rise, acc;
    @(negedge conv_clk);
    cval       = cval + 1'b1;
    coarse_cnt = cval;
    tap_vec    = v;
    rise    = v[0] && !m_prev0;
    m_prev0 = v[0];
    acc     = rise && (m_dead == 0);
    if (acc) m_dead = DEAD - 1;
    else if (m_dead > 0) m_dead--;
    if (acc) begin
      if (exp_q.size() < DEPTH) exp_q.push_back(mk_word(cval, $countones(v)));
      else if (m_ovf < (1 << OVF_W) - 1) m_ovf++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0);
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) step('0);
    idle(12);
    check(exp_q.size() == 0, "R8 drain", exp_q.size(), 0);
  endtask

  // reader
  initial begin
    logic [WORD_W-1:0] e;
    forever begin
      @(negedge rd_clk);
      if (rd_go && !rd_empty) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected word", rd_data, 0);
        end else begin
          e = exp_q.pop_front();
          check(rd_data[WORD_W-1 -: CHW] == e[WORD_W-1 -: CHW], "R6 channel",
                rd_data[WORD_W-1 -: CHW], e[WORD_W-1 -: CHW]);
          check(rd_data[FINE_W +: COARSE_W] == e[FINE_W +: COARSE_W], "R5 coarse",
                rd_data[FINE_W +: COARSE_W], e[FINE_W +: COARSE_W]);
          check(rd_data[FINE_W-1:0] == e[FINE_W-1:0], "R4 fine",
                rd_data[FINE_W-1:0], e[FINE_W-1:0]);
        end
        words_read++;
        rd_en = 1'b1;
      end else begin
        // R8: rd_en toggled while empty must not move anything
        rd_en = rd_go ? 1'($urandom_range(0, 1)) : 1'b0;
      end
    end
  end

  initial begin
    #700000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w0;
    logic [TAPS-1:0] v;
    void'($urandom(1234));
    #11;
    conv_rst_n = 1;
    rd_rst_n   = 1;
    @(negedge conv_clk);
    check(rd_empty == 1'b1, "R1 empty", rd_empty, 1);
    check(ovf_count == 0, "R1 ovf", ovf_count, 0);

    // R7: latency to FIFO write, reader paused
    idle(4);
    step('0);
    step(therm(40));          // hit snapshot at next edge
    step('0);
    check(rd_empty == 1'b1, "R7 early", rd_empty, 1);
    step('0);
    check(rd_empty == 1'b1, "R7 early", rd_empty, 1);
    idle(12);
    check(rd_empty == 1'b0, "R7 stored", rd_empty, 0);
    rd_go = 1;
    drain();

    // R3: edges inside the dead window ignored, edge at +DEAD accepted
    w0 = words_read;
    step(therm(10)); step('0); step(therm(20)); step('0);
    step(therm(30)); step('0); step(therm(50));
    drain();
    check(words_read - w0 == 2, "R3 dead window", words_read - w0, 2);

    // R2: tap 0 held high for many samples gives one hit
    w0 = words_read;
    for (int i = 0; i < 15; i++) step(therm(5 + i));
    drain();
    check(words_read - w0 == 1, "R2 level held", words_read - w0, 1);

    // R4 corners: one tap, all taps, bubble
    step(therm(1)); idle(6);
    step(therm(TAPS)); idle(6);
    v = therm(100); v[50] = 1'b0;
    step(v); idle(6);
    drain();

    // random traffic, coarse counter wraps several times (R5)
    for (int i = 0; i < 5000; i++) begin
      if ($urandom_range(0, 3) == 0) step('0);
      else step(therm($urandom_range(1, TAPS)));
    end
    drain();

    // R10 / R9: fill with reader paused
    rd_go = 0;
    idle(20);
    w0 = words_read;
    for (int i = 0; i < DEPTH + 4; i++) begin
      step(therm($urandom_range(1, TAPS)));
      idle(5);
    end
    idle(10);
    check(ovf_count == 4, "R9 drop count", ovf_count, 4);
    check(ovf_count == m_ovf, "R9 model", ovf_count, m_ovf);
    rd_go = 1;
    drain();
    check(words_read - w0 == DEPTH, "R10 depth", words_read - w0, DEPTH);

    // R9 saturation
    rd_go = 0;
    idle(20);
    for (int i = 0; i < 280; i++) begin
      step(therm($urandom_range(1, TAPS)));
      idle(5);
    end
    idle(10);
    check(ovf_count == 8'hFF, "R9 saturate", ovf_count, 255);
    rd_go = 1;
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule